// File: doc/BRIEF.md
# Serial Access Register Port

This block is the serial side of a dual-ported video memory. It keeps one row of column words in a register and points at one column of it. In output mode each rising edge of the serial clock puts the word under the pointer onto the serial data output and moves the pointer on. In input mode each legal rising edge writes the serial input word into the row at the pointer. The row register is visible in parallel so that the transfer controller can move it into the memory array during a write transfer.

The transfer controller drives the block with one-cycle pulses. A transfer request comes with a direction, a start column and, for a read, the new row data. The transfer-enable rise pulse completes a read transfer. The row-strobe rise pulse ends the row cycle of a write transfer. A read transfer that arrives while the port is already streaming does not stop the stream. The old row keeps shifting out until the transfer-enable rise has been seen. The next serial clock edge after that takes the first word of the new row, so no cycle is lost. The port also watches for serial clock edges in the two windows where they are forbidden. When one is seen it raises a sticky flag and ignores that edge.

The serial clock is sampled as a level on the system clock. A rising edge is the first system clock edge at which `sclk` is seen high after it was seen low.

Top module: `serial_access_port`

## Requirements
- R1: While reset is asserted and right after it is released, `sout` is 0, `sout_en` is 0, `viol` is 0 and every word of `row_out` is 0.
- R2: In output mode, with no transfer pending, each serial clock rise loads `sout` with the row word at the pointer and advances the pointer by one. After column COLS-1 the pointer returns to column 0.
- R3: After a read transfer (`xfr_write`=0) with start column C, the first serial clock rise after the `oe_rise` pulse puts word C of the newly loaded row on `sout`. Later rises give C+1, C+2 and so on, with wrapping.
- R4: While a read transfer is pending and the port is already in output mode, serial clock rises keep shifting out the old row. This holds up to and including the cycle of `oe_rise`, and the new row appears on the very next rise with no idle rise in between.
- R5: A write transfer (`xfr_write`=1) with start column C sets the port to input mode. After `rs_rise`, each serial clock rise writes `sin` into `row_out` word C, then C+1 and so on, wrapping after COLS-1. Word k occupies bits k*DW up to k*DW+DW-1.
- R6: A serial clock rise that falls between a write transfer request and its `rs_rise` (the `rs_rise` cycle included) sets `viol` and is ignored: `row_out` and the pointer are unchanged.
- R7: When a read transfer starts while the port is in input mode, a serial clock rise before or in the cycle of `oe_rise` sets `viol` and is ignored. `sout_en` stays 0 until the `oe_rise`.
- R8: Once set, `viol` stays 1 until reset.
- R9: `sout_en` is 1 from the cycle after the `oe_rise` that completes a read transfer and is 0 in input mode. While `sout_en` is 0, `sout` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock level, sampled on `clk` |
| sin | input | DW | Serial input word |
| xfr_req | input | 1 | One-cycle pulse: a transfer cycle starts |
| xfr_write | input | 1 | Transfer direction with `xfr_req`: 1 write, 0 read |
| xfr_col | input | $clog2(COLS) | Start column of the pointer |
| load_row | input | COLS*DW | New row for a read transfer, word k at bits k*DW and up |
| oe_rise | input | 1 | One-cycle pulse: transfer-enable rise, completes a read transfer |
| rs_rise | input | 1 | One-cycle pulse: row-strobe rise, ends a write transfer row cycle |
| sout | output | DW | Serial output word |
| sout_en | output | 1 | Output driver enable, 0 means tri-stated (input mode) |
| row_out | output | COLS*DW | Current row contents, word k at bits k*DW and up |
| viol | output | 1 | Sticky serial-clock timing violation flag |

## Verification
A pointer that is off by one, or that wraps in the wrong place, shows on `sout` at the very next serial clock rise as a word from the wrong column. A wrong write pointer shows on `row_out` one cycle after the rise. If the pending-row swap comes early or late, an old-row word appears where a new-row word was due, or the other way round. That is visible on the first rise after `oe_rise`. A stale direction or window state shows within one cycle as a wrong `sout_en`, a `viol` that rises when it should not (or fails to rise), or a row word that was written when it should have been ignored.

// File: rtl/sap_pkg.sv
package sap_pkg;
  typedef enum logic [1:0] {
    SAP_IDLE     = 2'd0,
    SAP_RD_WAIT  = 2'd1,
    SAP_RD_ARMED = 2'd2,
    SAP_WR_WAIT  = 2'd3
  } sap_state_e;
endpackage

// File: rtl/sap_edge.sv
module sap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rise
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
endmodule

// File: rtl/sap_ctrl.sv
module sap_ctrl
  import sap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic xfr_req,
  input  logic xfr_write,
  input  logic oe_rise,
  input  logic rs_rise,
  output logic mode_out,
  output logic swap,
  output logic step_out,
  output logic step_in,
  output logic viol
);
  sap_state_e st_q, st_d;
  logic       mode_q, mode_d;
  logic       viol_q, viol_d;
  logic       blocked;

  always_comb begin
    blocked  = (st_q == SAP_WR_WAIT) || ((st_q == SAP_RD_WAIT) && !mode_q);
    swap     = rise && (st_q == SAP_RD_ARMED);
    step_out = rise && !blocked && !swap && mode_q;
    step_in  = rise && !blocked && !mode_q;
    st_d     = st_q;
    mode_d   = mode_q;
    viol_d   = viol_q | (rise & blocked);
    if (xfr_req) begin
      if (xfr_write) begin
        st_d   = SAP_WR_WAIT;
        mode_d = 1'b0;
      end else begin
        st_d   = SAP_RD_WAIT;
      end
    end else begin
      case (st_q)
        SAP_RD_WAIT: if (oe_rise) begin
          st_d   = SAP_RD_ARMED;
          mode_d = 1'b1;
        end
        SAP_RD_ARMED: if (swap) st_d = SAP_IDLE;
        SAP_WR_WAIT:  if (rs_rise) st_d = SAP_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SAP_IDLE;
      mode_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      viol_q <= viol_d;
    end
  end

  assign mode_out = mode_q;
  assign viol     = viol_q;
endmodule

// File: rtl/sap_ptr.sv
module sap_ptr #(
  parameter int COLS = 16,
  localparam int PW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfr_req,
  input  logic          xfr_write,
  input  logic [PW-1:0] xfr_col,
  input  logic          swap,
  input  logic          step,
  output logic [PW-1:0] ptr,
  output logic [PW-1:0] pcol
);
  localparam logic [PW-1:0] LAST = PW'(COLS - 1);

  logic [PW-1:0] ptr_q, ptr_d, pcol_q, pcol_d;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    ptr_d  = ptr_q;
    pcol_d = pcol_q;
    if (xfr_req && xfr_write) ptr_d = xfr_col;
    else if (swap)            ptr_d = nxt(pcol_q);
    else if (step)            ptr_d = nxt(ptr_q);
    if (xfr_req && !xfr_write) pcol_d = xfr_col;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      pcol_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      pcol_q <= pcol_d;
    end
  end

  assign ptr  = ptr_q;
  assign pcol = pcol_q;
endmodule

// File: rtl/sap_row.sv
module sap_row #(
  parameter int COLS = 16,
  parameter int DW   = 4,
  localparam int PW  = $clog2(COLS),
  localparam int RW  = COLS * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_pend,
  input  logic [RW-1:0] load_row,
  input  logic          swap,
  input  logic          step_out,
  input  logic          step_in,
  input  logic [PW-1:0] ptr,
  input  logic [PW-1:0] pcol,
  input  logic [DW-1:0] sin,
  output logic [RW-1:0] row_out,
  output logic [DW-1:0] sout
);
  logic [DW-1:0] row_q  [COLS];
  logic [DW-1:0] pend_q [COLS];
  logic [DW-1:0] sout_q, sout_d;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic wr_en;
    assign wr_en = step_in && (ptr == PW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         row_q[c] <= '0;
      else if (swap)      row_q[c] <= pend_q[c];
      else if (wr_en)     row_q[c] <= sin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend_q[c] <= '0;
      else if (load_pend) pend_q[c] <= load_row[c*DW +: DW];
    end

    assign row_out[c*DW +: DW] = row_q[c];
  end

  always_comb begin
    sout_d = sout_q;
    if (swap)          sout_d = pend_q[pcol];
    else if (step_out) sout_d = row_q[ptr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sout_q <= '0;
    else        sout_q <= sout_d;
  end

  assign sout = sout_q;
endmodule

// File: rtl/serial_access_port.sv
module serial_access_port #(
  parameter int COLS = 16,
  parameter int DW   = 4,
  localparam int PW  = $clog2(COLS),
  localparam int RW  = COLS * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic [DW-1:0] sin,
  input  logic          xfr_req,
  input  logic          xfr_write,
  input  logic [PW-1:0] xfr_col,
  input  logic [RW-1:0] load_row,
  input  logic          oe_rise,
  input  logic          rs_rise,
  output logic [DW-1:0] sout,
  output logic          sout_en,
  output logic [RW-1:0] row_out,
  output logic          viol
);
  logic          rise, swap, step_out, step_in;
  logic [PW-1:0] ptr, pcol;

  sap_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sclk (sclk),
    .rise (rise)
  );

  sap_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise),
    .xfr_req  (xfr_req),
    .xfr_write(xfr_write),
    .oe_rise  (oe_rise),
    .rs_rise  (rs_rise),
    .mode_out (sout_en),
    .swap     (swap),
    .step_out (step_out),
    .step_in  (step_in),
    .viol     (viol)
  );

  sap_ptr #(.COLS(COLS)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfr_req  (xfr_req),
    .xfr_write(xfr_write),
    .xfr_col  (xfr_col),
    .swap     (swap),
    .step     (step_out | step_in),
    .ptr      (ptr),
    .pcol     (pcol)
  );

  sap_row #(.COLS(COLS), .DW(DW)) u_row (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_pend(xfr_req & ~xfr_write),
    .load_row (load_row),
    .swap     (swap),
    .step_out (step_out),
    .step_in  (step_in),
    .ptr      (ptr),
    .pcol     (pcol),
    .sin      (sin),
    .row_out  (row_out),
    .sout     (sout)
  );
endmodule

// File: rtl/serial_access_port_chk.sv
module serial_access_port_chk #(
  parameter int COLS = 16,
  parameter int DW   = 4,
  localparam int RW  = COLS * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sclk,
  input logic          xfr_req,
  input logic          xfr_write,
  input logic          oe_rise,
  input logic          rs_rise,
  input logic [DW-1:0] sout,
  input logic          sout_en,
  input logic [RW-1:0] row_out,
  input logic          viol
);
  logic sclk_seen, wr_win, rd_win, srise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_seen <= 1'b0;
      wr_win    <= 1'b0;
      rd_win    <= 1'b0;
    end else begin
      sclk_seen <= sclk;
      if (xfr_req) begin
        wr_win <= xfr_write;
        rd_win <= !xfr_write;
      end else begin
        if (rs_rise) wr_win <= 1'b0;
        if (oe_rise) rd_win <= 1'b0;
      end
    end
  end

  assign srise = sclk && !sclk_seen;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!viol && !sout_en && sout == '0 && row_out == '0));

  assert_write_input_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfr_req && xfr_write) |=> !sout_en);

  assert_window_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_win && srise) |=> viol);

  assert_window_row_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_win && !xfr_req) |=> $stable(row_out));

  assert_viol_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol);

  assert_oe_enables_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_win && oe_rise && !xfr_req) |=> sout_en);

  assert_quiet_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sout_en |=> $stable(sout));
endmodule

bind serial_access_port serial_access_port_chk #(.COLS(COLS), .DW(DW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .sclk     (sclk),
  .xfr_req  (xfr_req),
  .xfr_write(xfr_write),
  .oe_rise  (oe_rise),
  .rs_rise  (rs_rise),
  .sout     (sout),
  .sout_en  (sout_en),
  .row_out  (row_out),
  .viol     (viol)
);

// File: tb/serial_access_port_tb_top.sv
`timescale 1ns/1ps
module serial_access_port_tb_top;
  localparam int COLS = 16;
  localparam int DW   = 4;
  localparam int PW   = $clog2(COLS);
  localparam int RW   = COLS * DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sclk = 1'b0;
  logic [DW-1:0] sin = '0;
  logic          xfr_req = 1'b0;
  logic          xfr_write = 1'b0;
  logic [PW-1:0] xfr_col = '0;
  logic [RW-1:0] load_row = '0;
  logic          oe_rise = 1'b0;
  logic          rs_rise = 1'b0;
  logic [DW-1:0] sout;
  logic          sout_en;
  logic [RW-1:0] row_out;
  logic          viol;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  serial_access_port #(.COLS(COLS), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sin(sin),
    .xfr_req(xfr_req), .xfr_write(xfr_write), .xfr_col(xfr_col),
    .load_row(load_row), .oe_rise(oe_rise), .rs_rise(rs_rise),
    .sout(sout), .sout_en(sout_en), .row_out(row_out), .viol(viol)
  );

  // Behavioural reference: phase flags and plain integers
  logic [DW-1:0] m_row  [COLS];
  logic [DW-1:0] m_pend [COLS];
  logic [DW-1:0] m_sout;
  int  m_ptr, m_pcol;
  bit  m_out, m_viol, m_sclk_prev;
  bit  rd_pending, rd_ready, wr_busy;

  function automatic logic [DW-1:0] word_a(int c); return DW'((c * 3 + 1) % 16); endfunction
  function automatic logic [DW-1:0] word_b(int c); return DW'((15 - c) ^ 5); endfunction

  function automatic logic [RW-1:0] pack_a();
    logic [RW-1:0] v;
    for (int c = 0; c < COLS; c++) v[c*DW +: DW] = word_a(c);
    return v;
  endfunction
  function automatic logic [RW-1:0] pack_b();
    logic [RW-1:0] v;
    for (int c = 0; c < COLS; c++) v[c*DW +: DW] = word_b(c);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < COLS; c++) begin m_row[c] = '0; m_pend[c] = '0; end
      m_sout = '0; m_ptr = 0; m_pcol = 0; m_out = 0; m_viol = 0; m_sclk_prev = 0;
      rd_pending = 0; rd_ready = 0; wr_busy = 0;
    end else begin
      bit r, bad;
      r = sclk && !m_sclk_prev;
      m_sclk_prev = sclk;
      bad = wr_busy || (rd_pending && !m_out);
      if (r) begin
        if (bad) m_viol = 1;
        else if (rd_ready) begin
          for (int c = 0; c < COLS; c++) m_row[c] = m_pend[c];
          m_sout = m_row[m_pcol];
          m_ptr = (m_pcol + 1) % COLS;
          rd_ready = 0;
        end else if (m_out) begin
          m_sout = m_row[m_ptr];
          m_ptr = (m_ptr + 1) % COLS;
        end else begin
          m_row[m_ptr] = sin;
          m_ptr = (m_ptr + 1) % COLS;
        end
      end
      if (xfr_req) begin
        if (xfr_write) begin
          m_out = 0; m_ptr = int'(xfr_col); wr_busy = 1; rd_pending = 0; rd_ready = 0;
        end else begin
          for (int c = 0; c < COLS; c++) m_pend[c] = load_row[c*DW +: DW];
          m_pcol = int'(xfr_col); rd_pending = 1; rd_ready = 0; wr_busy = 0;
        end
      end else if (oe_rise && rd_pending) begin
        m_out = 1; rd_pending = 0; rd_ready = 1;
      end else if (rs_rise && wr_busy) begin
        wr_busy = 0;
      end
    end
  end

  always @(negedge clk) begin
    logic [RW-1:0] exp_row;
    for (int c = 0; c < COLS; c++) exp_row[c*DW +: DW] = m_row[c];
    compared++;
    if (sout !== m_sout || sout_en !== m_out || viol !== m_viol || row_out !== exp_row) begin
      mismatched++;
      $display("FAIL %s cycle compare: sout=%0h/%0h en=%0b/%0b viol=%0b/%0b row=%0h/%0h (actual/expected)",
               cur_req, sout, m_sout, sout_en, m_out, viol, m_viol, row_out, exp_row);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); #2 rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic pulse(input logic [DW-1:0] v);
    sclk = 1'b1; sin = v; cyc();
    sclk = 1'b0; cyc();
  endtask

  task automatic xfr(input bit wr, input int col, input logic [RW-1:0] row);
    xfr_req = 1'b1; xfr_write = wr; xfr_col = PW'(col); load_row = row; cyc();
    xfr_req = 1'b0; xfr_write = 1'b0; cyc();
  endtask

  task automatic oe();  oe_rise = 1'b1; cyc(); oe_rise = 1'b0; cyc(); endtask
  task automatic rs();  rs_rise = 1'b1; cyc(); rs_rise = 1'b0; cyc(); endtask

  initial begin
    logic [DW-1:0] vals [6] = '{4'h9, 4'h3, 4'hC, 4'h7, 4'h1, 4'hE};
    int cols [6] = '{14, 15, 0, 1, 2, 3};
    cyc(3);
    cur_req = "R1";
    check(sout == '0 && !sout_en && !viol && row_out == '0, "R1 reset state", int'(viol), 0);
    rst_n = 1'b1; cyc(2);
    check(sout == '0 && !sout_en && !viol && row_out == '0, "R1 after release", int'(sout_en), 0);

    // Rise inside write-transfer row cycle
    cur_req = "R6";
    xfr(1'b1, 2, '0);
    pulse(4'h9);
    check(viol == 1'b1, "R6 viol set", int'(viol), 1);
    check(row_out == '0, "R6 row untouched", int'(row_out[11:8]), 0);
    rs();
    cur_req = "R8";
    cyc(4);
    check(viol == 1'b1, "R8 viol sticky", int'(viol), 1);
    do_reset(); cyc();
    check(viol == 1'b0, "R8 cleared by reset", int'(viol), 0);

    // Clean write transfer, capture with wrap
    cur_req = "R5";
    xfr(1'b1, 14, '0);
    check(!sout_en, "R5 input mode", int'(sout_en), 0);
    rs();
    for (int i = 0; i < 6; i++) pulse(vals[i]);
    for (int i = 0; i < 6; i++)
      check(row_out[cols[i]*DW +: DW] == vals[i], "R5 captured word",
            int'(row_out[cols[i]*DW +: DW]), int'(vals[i]));
    check(!viol, "R5 no violation", int'(viol), 0);

    // Read transfer after write, legal timing
    cur_req = "R3";
    xfr(1'b0, 3, pack_a());
    check(!sout_en, "R9 still input before oe", int'(sout_en), 0);
    oe();
    check(sout_en, "R9 output after oe", int'(sout_en), 1);
    pulse('0);
    check(sout == word_a(3), "R3 first new word", int'(sout), int'(word_a(3)));
    cur_req = "R2";
    for (int k = 2; k <= 13; k++) pulse('0);
    check(sout == word_a(15), "R2 last column", int'(sout), int'(word_a(15)));
    pulse('0);
    check(sout == word_a(0), "R2 wrap to column 0", int'(sout), int'(word_a(0)));
    pulse('0);

    // Real-time read: old row streams until oe + next rise
    cur_req = "R4";
    xfr(1'b0, 10, pack_b());
    pulse('0);
    check(sout == word_a(2), "R4 old row continues", int'(sout), int'(word_a(2)));
    oe_rise = 1'b1; sclk = 1'b1; cyc();
    oe_rise = 1'b0; sclk = 1'b0; cyc();
    check(sout == word_a(3), "R4 rise with oe keeps old row", int'(sout), int'(word_a(3)));
    pulse('0);
    check(sout == word_b(10), "R4 new row no gap", int'(sout), int'(word_b(10)));
    pulse('0);
    check(sout == word_b(11), "R3 new row next word", int'(sout), int'(word_b(11)));
    check(!viol, "R4 no violation", int'(viol), 0);

    // Read after write with an illegal rise
    cur_req = "R7";
    xfr(1'b1, 0, '0);
    rs();
    xfr(1'b0, 5, pack_a());
    pulse(4'h6);
    check(viol && !sout_en, "R7 viol and still input", int'({viol, sout_en}), 2);
    check(row_out[3:0] == word_b(0), "R7 rise ignored", int'(row_out[3:0]), int'(word_b(0)));
    oe();
    check(sout_en, "R9 enabled after oe", int'(sout_en), 1);
    pulse('0);
    check(sout == word_a(5), "R3 after recovery", int'(sout), int'(word_a(5)));
    cur_req = "R8";
    cyc(5);
    check(viol, "R8 still set", int'(viol), 1);
    cur_req = "R1";
    do_reset(); cyc();
    check(sout == '0 && !sout_en && !viol && row_out == '0, "R1 second reset", int'(viol), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule